// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block is a small bank of control registers for the I/O companion chip of a workstation. Seven registers sit behind a synchronous register interface, and each has its own select line. Five are 8-bit registers: configuration, diagnostic, modem control and two auxiliary registers. The other two are a 16-bit LED register and a 32-bit system control register. Address decoding above the per-register selects is done outside the block. Each register accepts only accesses of its own width. An access of any other width completes with an error flag and has no effect.

Several bits have side effects:

- A write to the first auxiliary register can fire a one-cycle floppy terminal-count pulse.
- The second auxiliary register holds a power-fail status bit. That bit follows an external power-failing input, is gated by an enable in the configuration register, and is cleared only by an explicit clear bit. It also drives the interrupt output.
- A power-off bit raises a shutdown request.
- The system control register raises a system reset request and records a reset status.

There are two resets. The block reset `rst` deliberately leaves the diagnostic, LED and system control registers untouched. A separate power-on reset `por` clears every register.

Top module: `aux_ctrl_bank`

## Requirements
- R1: `irq` is high exactly when the power-fail status (auxiliary 2 bit 5) and the power interrupt enable (configuration bit 3) are both set, evaluated on the current register contents.
- R2: In a cycle where `pwr_failing` differs from its value in the previous cycle, the power-fail status bit is set if the input is now high and configuration bit 3 was set before that edge. In every other case the bit is cleared. This input update takes priority over an auxiliary 2 write in the same cycle.
- R3: A write to auxiliary 1 (select 3) with bit 1 set makes `tc_pulse` high for exactly the next cycle. Bit 1 is stored as 0 and the other seven bits are stored as written.
- R4: A write to auxiliary 2 (select 4) takes only bit 0 (power off) from the data. Bit 5 keeps its value unless written bit 1 (clear) is 1, which clears every bit except bit 0. Bit 1 always reads back as 0.
- R5: An auxiliary 2 write with bit 0 set makes `shutdown_req` high for exactly the next cycle.
- R6: A 32-bit write at offset 0 to system control (select 6) with bit 0 set loads the register with 0x00000002 and makes `reset_req` high for the next cycle. With bit 0 clear, the write changes nothing.
- R7: `rst` clears configuration, modem, auxiliary 1 and auxiliary 2, and keeps the diagnostic, LED and system control registers. `por` clears all registers.
- R8: Registers on selects 0 to 4 need `size`=0 (byte), the LED register (select 5) needs `size`=1 (16-bit), and system control (select 6) needs `size`=2 (32-bit); `size`=3 is never valid. A width mismatch sets `err` for the next cycle, changes no register and returns zero read data.
- R9: The LED and system control registers respond only at `addr`=0. Reads at any other offset return zero and writes there are ignored, without an error.
- R10: Read data appears on `rdata` in the cycle after `rd_en`, zero-extended. `rdata` is zero in every other cycle.
- R11: The configuration (select 0), diagnostic (select 1), modem (select 2) and LED registers store written data exactly and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| por | input | 1 | Synchronous active-high power-on reset |
| sel | input | 7 | One-hot register select: 0 cfg, 1 diag, 2 modem, 3 aux1, 4 aux2, 5 LED, 6 system control |
| size | input | 2 | Access width: 0 byte, 1 16-bit, 2 32-bit |
| addr | input | 4 | Byte offset within the selected register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | Width error, one cycle after the access |
| pwr_failing | input | 1 | External power-failing indication |
| irq | output | 1 | Power-fail interrupt |
| tc_pulse | output | 1 | Floppy terminal-count pulse |
| shutdown_req | output | 1 | Shutdown request pulse |
| reset_req | output | 1 | System reset request pulse |

## Verification
Some rules are checked on every cycle by the assertions. Each pulse output (terminal count, shutdown, reset request) and the error flag must be traced back to an access of the right kind in the cycle before it. The interrupt may be high only while the power-failing input was high on the previous edge. Access strobes must select at most one register.

Other behaviour depends on history, and only the bench's scenarios, compared against a behavioural model on every clock, can show it:
- the stored values themselves, including the masked bit 1 of both auxiliary registers;
- the power-fail bit staying sticky after the interrupt enable is dropped, and a set enable not raising the bit until the input changes;
- clear-on-write while the input is still failing;
- which registers survive a block reset but not a power-on reset;
- silent offsets on the two wide registers.

// File: rtl/aux_ctrl_pkg.sv
package aux_ctrl_pkg;

  localparam int NUM_REGS = 7;

  typedef enum logic [2:0] {
    RI_CFG   = 3'd0,
    RI_DIAG  = 3'd1,
    RI_MODEM = 3'd2,
    RI_AUX1  = 3'd3,
    RI_AUX2  = 3'd4,
    RI_LED   = 3'd5,
    RI_SYS   = 3'd6
  } reg_idx_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_t;

  // bit positions the block's behaviour depends on
  localparam int CFG_PIE_BIT  = 3;
  localparam int AUX1_TC_BIT  = 1;
  localparam int AUX2_OFF_BIT = 0;
  localparam int AUX2_CLR_BIT = 1;
  localparam int AUX2_PF_BIT  = 5;
  localparam int SYS_RST_BIT  = 0;
  localparam int SYS_STAT_BIT = 1;

  function automatic acc_size_t width_for(int unsigned idx);
    if (idx == int'(RI_LED)) return SZ_HALF;
    if (idx == int'(RI_SYS)) return SZ_WORD;
    return SZ_BYTE;
  endfunction

endpackage

// File: rtl/aux_ctrl_decode.sv
module aux_ctrl_decode
  import aux_ctrl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [NUM_REGS-1:0] sel,
  input  logic [1:0]          size,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic                rd_en,
  output logic [NUM_REGS-1:0] wr_hit,
  output logic [NUM_REGS-1:0] rd_hit,
  output logic                width_bad
);

  logic [NUM_REGS-1:0] wmatch;
  logic [NUM_REGS-1:0] offok;
  logic [NUM_REGS-1:0] good;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam acc_size_t NEED = width_for(i);
    assign wmatch[i] = (size == NEED);
    if (i >= int'(RI_LED)) begin : g_wide
      assign offok[i] = (addr == '0);
    end else begin : g_byte
      assign offok[i] = 1'b1;
    end
    assign good[i] = sel[i] & wmatch[i] & offok[i];
  end

  assign wr_hit    = wr_en ? good : '0;
  assign rd_hit    = rd_en ? good : '0;
  assign width_bad = (wr_en | rd_en) & (|(sel & ~wmatch));

endmodule

// File: rtl/aux_pwr_fail.sv
module aux_pwr_fail
  import aux_ctrl_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_aux2,
  input  logic             wr_off,
  input  logic             wr_clr,
  input  logic             pie,
  input  logic             pf_in,
  output logic [REG_W-1:0] aux2_q,
  output logic             shut_q
);

  logic             pf_prev;
  logic [REG_W-1:0] aux2_d;

  always_comb begin
    aux2_d = aux2_q;
    if (wr_aux2) begin
      aux2_d               = '0;
      aux2_d[AUX2_OFF_BIT] = wr_off;
      aux2_d[AUX2_PF_BIT]  = aux2_q[AUX2_PF_BIT] & ~wr_clr;
    end
    if (pf_in != pf_prev) begin
      aux2_d[AUX2_PF_BIT] = pf_in & pie;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aux2_q  <= '0;
      pf_prev <= 1'b0;
      shut_q  <= 1'b0;
    end else begin
      aux2_q  <= aux2_d;
      pf_prev <= pf_in;
      shut_q  <= wr_aux2 & wr_off;
    end
  end

endmodule

// File: rtl/aux_ctrl_bank.sv
module aux_ctrl_bank
  import aux_ctrl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int LED_W  = 16,
  parameter int REG_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                por,
  input  logic [NUM_REGS-1:0] sel,
  input  logic [1:0]          size,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic                err,
  input  logic                pwr_failing,
  output logic                irq,
  output logic                tc_pulse,
  output logic                shutdown_req,
  output logic                reset_req
);

  localparam logic [DATA_W-1:0] SYS_STAT_VAL = DATA_W'(1) << SYS_STAT_BIT;
  localparam logic [REG_W-1:0]  AUX1_KEEP    = ~(REG_W'(1) << AUX1_TC_BIT);

  logic [NUM_REGS-1:0] wr_hit, rd_hit;
  logic                width_bad;
  logic                clr_all;

  logic [REG_W-1:0]  cfg_q, diag_q, mdm_q, aux1_q, aux2_q;
  logic [LED_W-1:0]  led_q;
  logic [DATA_W-1:0] sys_q;
  logic [DATA_W-1:0] rd_nxt;
  logic              tc_q, rr_q, err_q, shut_q;
  logic [DATA_W-1:0] rdata_q;

  assign clr_all = rst | por;

  aux_ctrl_decode #(.ADDR_W(ADDR_W)) dec_i (
    .sel       (sel),
    .size      (size),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wr_hit    (wr_hit),
    .rd_hit    (rd_hit),
    .width_bad (width_bad)
  );

  aux_pwr_fail #(.REG_W(REG_W)) pwr_i (
    .clk     (clk),
    .rst     (clr_all),
    .wr_aux2 (wr_hit[RI_AUX2]),
    .wr_off  (wdata[AUX2_OFF_BIT]),
    .wr_clr  (wdata[AUX2_CLR_BIT]),
    .pie     (cfg_q[CFG_PIE_BIT]),
    .pf_in   (pwr_failing),
    .aux2_q  (aux2_q),
    .shut_q  (shut_q)
  );

  // registers cleared by the block reset
  always_ff @(posedge clk) begin
    if (clr_all) begin
      cfg_q  <= '0;
      mdm_q  <= '0;
      aux1_q <= '0;
      tc_q   <= 1'b0;
    end else begin
      tc_q <= 1'b0;
      if (wr_hit[RI_CFG])   cfg_q <= wdata[REG_W-1:0];
      if (wr_hit[RI_MODEM]) mdm_q <= wdata[REG_W-1:0];
      if (wr_hit[RI_AUX1]) begin
        aux1_q <= wdata[REG_W-1:0] & AUX1_KEEP;
        tc_q   <= wdata[AUX1_TC_BIT];
      end
    end
  end

  // registers that survive the block reset
  always_ff @(posedge clk) begin
    if (por) begin
      diag_q <= '0;
      led_q  <= '0;
      sys_q  <= '0;
    end else begin
      if (wr_hit[RI_DIAG]) diag_q <= wdata[REG_W-1:0];
      if (wr_hit[RI_LED])  led_q  <= wdata[LED_W-1:0];
      if (wr_hit[RI_SYS] && wdata[SYS_RST_BIT]) sys_q <= SYS_STAT_VAL;
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (rd_hit[RI_CFG])   rd_nxt[REG_W-1:0] = cfg_q;
    if (rd_hit[RI_DIAG])  rd_nxt[REG_W-1:0] = diag_q;
    if (rd_hit[RI_MODEM]) rd_nxt[REG_W-1:0] = mdm_q;
    if (rd_hit[RI_AUX1])  rd_nxt[REG_W-1:0] = aux1_q;
    if (rd_hit[RI_AUX2])  rd_nxt[REG_W-1:0] = aux2_q;
    if (rd_hit[RI_LED])   rd_nxt[LED_W-1:0] = led_q;
    if (rd_hit[RI_SYS])   rd_nxt            = sys_q;
  end

  always_ff @(posedge clk) begin
    if (clr_all) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
      rr_q    <= 1'b0;
    end else begin
      rdata_q <= rd_nxt;
      err_q   <= width_bad;
      rr_q    <= wr_hit[RI_SYS] & wdata[SYS_RST_BIT];
    end
  end

  assign rdata        = rdata_q;
  assign err          = err_q;
  assign tc_pulse     = tc_q;
  assign shutdown_req = shut_q;
  assign reset_req    = rr_q;
  assign irq          = aux2_q[AUX2_PF_BIT] & cfg_q[CFG_PIE_BIT];

endmodule

// File: rtl/aux_ctrl_bank_chk.sv
module aux_ctrl_bank_chk
  import aux_ctrl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                por,
  input logic [NUM_REGS-1:0] sel,
  input logic [1:0]          size,
  input logic [ADDR_W-1:0]   addr,
  input logic                wr_en,
  input logic                rd_en,
  input logic [DATA_W-1:0]   wdata,
  input logic [DATA_W-1:0]   rdata,
  input logic                err,
  input logic                pwr_failing,
  input logic                irq,
  input logic                tc_pulse,
  input logic                shutdown_req,
  input logic                reset_req
);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst || por)
    (wr_en || rd_en) |-> $onehot0(sel)); // R8

  AST_TC_CAUSE: assert property (@(posedge clk) disable iff (rst || por)
    tc_pulse |-> $past(wr_en && sel[3] && size == 2'd0 && wdata[1])); // R3

  AST_SHUT_CAUSE: assert property (@(posedge clk) disable iff (rst || por)
    shutdown_req |-> $past(wr_en && sel[4] && size == 2'd0 && wdata[0])); // R5

  AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (rst || por)
    reset_req |-> $past(wr_en && sel[6] && size == 2'd2 && addr == '0 && wdata[0])); // R6

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst || por)
    err |-> $past((wr_en || rd_en) &&
                  ((|sel[4:0] && size != 2'd0) ||
                   (sel[5] && size != 2'd1) ||
                   (sel[6] && size != 2'd2)))); // R8

  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst || por)
    err |-> (rdata == '0)); // R8

  AST_IRQ_NEEDS_FAIL: assert property (@(posedge clk) disable iff (rst || por)
    irq |-> $past(pwr_failing)); // R1

endmodule

bind aux_ctrl_bank aux_ctrl_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .por          (por),
  .sel          (sel),
  .size         (size),
  .addr         (addr),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .wdata        (wdata),
  .rdata        (rdata),
  .err          (err),
  .pwr_failing  (pwr_failing),
  .irq          (irq),
  .tc_pulse     (tc_pulse),
  .shutdown_req (shutdown_req),
  .reset_req    (reset_req)
);

// File: tb/aux_ctrl_bank_tb.sv
`timescale 1ns/1ps
module aux_ctrl_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        por = 1'b1;
  logic [6:0]  sel = '0;
  logic [1:0]  size = '0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err, irq, tc_pulse, shutdown_req, reset_req;
  logic        pwr_failing = 1'b0;

  always #4 clk = ~clk;

  aux_ctrl_bank dut_i (
    .clk(clk), .rst(rst), .por(por), .sel(sel), .size(size), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .err(err),
    .pwr_failing(pwr_failing), .irq(irq), .tc_pulse(tc_pulse),
    .shutdown_req(shutdown_req), .reset_req(reset_req)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R7";
  string exp_req  = "R7";
  bit    started  = 1'b0;

  // behavioural reference state
  logic [7:0]  m_cfg = 0, m_diag = 0, m_mdm = 0, m_aux1 = 0, m_aux2 = 0;
  logic [15:0] m_led = 0;
  logic [31:0] m_sys = 0;
  logic        m_pfprev = 0;
  logic [31:0] e_rd = 0;
  logic        e_err = 0, e_tc = 0, e_shut = 0, e_rr = 0;

  function automatic logic [31:0] mval(int i);
    case (i)
      0: return {24'h0, m_cfg};
      1: return {24'h0, m_diag};
      2: return {24'h0, m_mdm};
      3: return {24'h0, m_aux1};
      4: return {24'h0, m_aux2};
      5: return {16'h0, m_led};
      default: return m_sys;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [7:0] ocfg;
    int idx;
    int need;
    logic [7:0] n2;
    started = 1'b1;
    exp_req = cur_req;
    e_rd = 0; e_err = 0; e_tc = 0; e_shut = 0; e_rr = 0;
    if (por) begin
      m_cfg = 0; m_diag = 0; m_mdm = 0; m_aux1 = 0; m_aux2 = 0;
      m_led = 0; m_sys = 0; m_pfprev = 0;
    end else if (rst) begin
      m_cfg = 0; m_mdm = 0; m_aux1 = 0; m_aux2 = 0; m_pfprev = 0;
    end else begin
      ocfg = m_cfg;
      idx = -1;
      for (int i = 0; i < 7; i++) if (sel[i]) idx = i;
      if ((wr_en || rd_en) && idx >= 0) begin
        need = (idx == 5) ? 1 : (idx == 6) ? 2 : 0;
        if (int'(size) != need) e_err = 1;
        else if (idx < 5 || addr == 0) begin
          if (rd_en) e_rd = mval(idx);
          if (wr_en) begin
            case (idx)
              0: m_cfg = wdata[7:0];
              1: m_diag = wdata[7:0];
              2: m_mdm = wdata[7:0];
              3: begin e_tc = wdata[1]; m_aux1 = wdata[7:0] & 8'hFD; end
              4: begin
                n2 = 8'h00;
                n2[0] = wdata[0];
                if (!wdata[1]) n2[5] = m_aux2[5];
                m_aux2 = n2;
                e_shut = wdata[0];
              end
              5: m_led = wdata[15:0];
              default: if (wdata[0]) begin m_sys = 32'h2; e_rr = 1; end
            endcase
          end
        end
      end
      if (pwr_failing != m_pfprev) m_aux2[5] = pwr_failing & ocfg[3];
      m_pfprev = pwr_failing;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(exp_req, "rdata", rdata, e_rd);
      chk(exp_req, "err", {31'h0, err}, {31'h0, e_err});
      chk(exp_req, "tc_pulse", {31'h0, tc_pulse}, {31'h0, e_tc});
      chk(exp_req, "shutdown_req", {31'h0, shutdown_req}, {31'h0, e_shut});
      chk(exp_req, "reset_req", {31'h0, reset_req}, {31'h0, e_rr});
      chk(exp_req, "irq", {31'h0, irq}, {31'h0, m_aux2[5] & m_cfg[3]});
    end
  end

  task automatic acc(bit wr, int idx, logic [1:0] sz, logic [3:0] a,
                     logic [31:0] d, string req);
    @(negedge clk);
    cur_req = req;
    sel = 7'(1) << idx; size = sz; addr = a; wdata = d;
    wr_en = wr; rd_en = !wr;
    @(negedge clk);
    sel = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0; addr = '0; size = '0;
  endtask

  task automatic set_pf(logic v, string req);
    @(negedge clk);
    cur_req = req;
    pwr_failing = v;
    @(negedge clk);
  endtask

  bit done = 1'b0;

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por = 1'b0; rst = 1'b0;
    // R11 plain registers
    acc(1, 0, 2'd0, 0, 32'h0000_00A5, "R11");
    acc(1, 1, 2'd0, 0, 32'h0000_003C, "R11");
    acc(1, 2, 2'd0, 0, 32'h0000_005A, "R11");
    acc(1, 5, 2'd1, 0, 32'h0000_BEEF, "R11");
    acc(0, 0, 2'd0, 0, 0, "R10");
    acc(0, 1, 2'd0, 0, 0, "R11");
    acc(0, 2, 2'd0, 0, 0, "R11");
    acc(0, 5, 2'd1, 0, 0, "R11");
    // R3 terminal count
    acc(1, 3, 2'd0, 0, 32'h0000_00FF, "R3");
    acc(0, 3, 2'd0, 0, 0, "R3");
    acc(1, 3, 2'd0, 0, 32'h0000_0040, "R3");
    acc(0, 3, 2'd0, 0, 0, "R3");
    // R1/R2 power fail gating
    acc(1, 0, 2'd0, 0, 32'h0000_0008, "R2");
    set_pf(1, "R2");
    acc(0, 4, 2'd0, 0, 0, "R2");
    acc(1, 0, 2'd0, 0, 32'h0000_0000, "R1");
    acc(1, 0, 2'd0, 0, 32'h0000_0008, "R1");
    set_pf(0, "R2");
    acc(0, 4, 2'd0, 0, 0, "R2");
    acc(1, 0, 2'd0, 0, 32'h0000_0000, "R2");
    set_pf(1, "R2");
    acc(1, 0, 2'd0, 0, 32'h0000_0008, "R1");
    acc(0, 4, 2'd0, 0, 0, "R2");
    set_pf(0, "R2");
    set_pf(1, "R2");
    // R4/R5 auxiliary 2 writes
    acc(1, 4, 2'd0, 0, 32'h0000_00FC, "R4");
    acc(0, 4, 2'd0, 0, 0, "R4");
    acc(1, 4, 2'd0, 0, 32'h0000_0002, "R4");
    acc(0, 4, 2'd0, 0, 0, "R4");
    acc(1, 4, 2'd0, 0, 32'h0000_0001, "R5");
    acc(0, 4, 2'd0, 0, 0, "R5");
    acc(1, 4, 2'd0, 0, 32'h0000_0003, "R5");
    acc(0, 4, 2'd0, 0, 0, "R4");
    // input change together with a clearing write
    @(negedge clk);
    cur_req = "R2";
    pwr_failing = 1'b0;
    sel = 7'b001_0000; wr_en = 1'b1; wdata = 32'h2;
    @(negedge clk);
    sel = '0; wr_en = 1'b0; wdata = '0;
    acc(0, 4, 2'd0, 0, 0, "R2");
    // R6 system control
    acc(1, 6, 2'd2, 0, 32'h0000_0000, "R6");
    acc(0, 6, 2'd2, 0, 0, "R6");
    acc(1, 6, 2'd2, 0, 32'hFFFF_FFF1, "R6");
    acc(0, 6, 2'd2, 0, 0, "R6");
    // R9 offsets
    acc(1, 5, 2'd1, 4'd2, 32'h0000_1234, "R9");
    acc(0, 5, 2'd1, 4'd2, 0, "R9");
    acc(0, 5, 2'd1, 0, 0, "R9");
    acc(1, 6, 2'd2, 4'd4, 32'h1, "R9");
    acc(0, 6, 2'd2, 4'd4, 0, "R9");
    // R8 widths
    acc(1, 0, 2'd1, 0, 32'h0000_0077, "R8");
    acc(0, 0, 2'd0, 0, 0, "R8");
    acc(0, 5, 2'd0, 0, 0, "R8");
    acc(1, 6, 2'd3, 0, 32'h1, "R8");
    acc(1, 4, 2'd2, 0, 32'h1, "R8");
    acc(0, 6, 2'd2, 0, 0, "R8");
    // R7 block reset keeps diag, LED, system control
    acc(1, 3, 2'd0, 0, 32'h0000_0081, "R7");
    acc(1, 2, 2'd0, 0, 32'h0000_0011, "R7");
    @(negedge clk);
    cur_req = "R7";
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 7; i++)
      acc(0, i, (i == 5) ? 2'd1 : (i == 6) ? 2'd2 : 2'd0, 0, 0, "R7");
    @(negedge clk);
    por = 1'b1;
    repeat (2) @(negedge clk);
    por = 1'b0;
    for (int i = 0; i < 7; i++)
      acc(0, i, (i == 5) ? 2'd1 : (i == 6) ? 2'd2 : 2'd0, 0, 0, "R7");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule